// File: doc/BRIEF.md
# Game Port Chip Select Decoder

This block produces an active-low chip select for a game port that sits in the 10-bit I/O space. A single 8-bit configuration register holds two things. Its upper six bits give bits 9 to 4 of the base address. Its lower two bits choose how much of the 16-byte window around that base is claimed. Depending on that choice, the block claims nothing, one byte, the lower eight bytes, or all sixteen bytes. The select is formed combinationally from the address bus, the host chip-select input, address line 10, the register contents and an external disable bit.

The register sits behind the chip's configuration index. It can be written or read only while the configuration-state flag is high and the index input equals the register's own index. Outside that window, writes leave the register untouched and reads return zero. The sequence that enters configuration mode belongs to another block.

Top module: `gamecs_top`

## Requirements
- R1: After reset the register holds 80h, so a qualified read returns 80h and the select is inactive.
- R2: A write strobe, taken at a rising clock edge while the configuration flag is high and the index equals 1Eh, loads the write data into the register; the new value is visible from that edge onward.
- R3: A write strobe taken while the configuration flag is low, or while the index differs from 1Eh, leaves the register unchanged.
- R4: The read data is 00h unless the read strobe is high, the configuration flag is high and the index equals 1Eh; when all three hold, the read data is the register value.
- R5: Mode 00 in register bits 1:0 keeps the select high (inactive) for every address.
- R6: Mode 01 asserts the select only when address bits 9:4 equal register bits 7:2 and address bits 3:0 equal 0001b.
- R7: Mode 10 asserts the select when address bits 9:4 equal register bits 7:2 and address bit 3 is 0.
- R8: Mode 11 asserts the select for all sixteen addresses whose bits 9:4 equal register bits 7:2; bases from 100h up to 3F0h all decode.
- R9: The select stays high whenever the host chip-select input is high or address line 10 is high.
- R10: While the disable input is high, the select stays high regardless of mode.
- R11: A programmed base below 100h (register bits 7:6 equal 00b) never asserts the select.
- R12: The select follows address changes in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgActive | input | 1 | High while the chip is in configuration state |
| cfgIndex | input | 8 | Current configuration index value |
| cfgWrite | input | 1 | Register write strobe |
| cfgRead | input | 1 | Register read strobe |
| cfgWdata | input | 8 | Write data |
| cfgRdata | output | 8 | Read data, zero when not selected |
| ioAddr | input | 10 | I/O address bits 9 to 0 |
| csInN | input | 1 | Host chip select, active low |
| addr10 | input | 1 | Address line 10 |
| gameOff | input | 1 | Disable for the game select function |
| gameCsN | output | 1 | Game port chip select, active low |

## Verification
The bench builds the block with its default parameters: a 10-bit address, 16-byte windows, index 1Eh, reset value 80h and a lowest legal base of 100h. With these values, both ends of the legal base range (100h and 3F0h) can be programmed directly. Bases below the legal range (0F0h and 000h) can also be programmed, which tests the lower cutoff. The byte-at-offset-1 and half-window modes have their edges placed at offsets 0, 1, 2, 7 and 8, and the neighbouring windows are probed on both sides.

// File: rtl/gamecs_pkg.sv
`timescale 1ns/1ps
package gamecs_pkg;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } cfgStrobe_t;

  typedef enum logic [1:0] {
    DEC_OFF  = 2'b00,
    DEC_BYTE = 2'b01,
    DEC_HALF = 2'b10,
    DEC_FULL = 2'b11
  } decMode_t;

endpackage

// File: rtl/gamecs_ctrl.sv
`timescale 1ns/1ps
module gamecs_ctrl
  import gamecs_pkg::*;
#(
  parameter int              IDX_W     = 8,
  parameter logic [IDX_W-1:0] CFG_INDEX = 8'h1E
) (
  input  logic             cfgActive,
  input  logic [IDX_W-1:0] cfgIndex,
  input  logic             cfgWrite,
  input  logic             cfgRead,
  output cfgStrobe_t       strobe
);

  logic selHit;

  // The register is reachable only in configuration state at its own index.
  always_comb begin
    selHit      = cfgActive && (cfgIndex == CFG_INDEX);
    strobe.wrEn = selHit && cfgWrite;
    strobe.rdEn = selHit && cfgRead;
  end

endmodule

// File: rtl/gamecs_dp.sv
`timescale 1ns/1ps
module gamecs_dp
  import gamecs_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int BLK_W    = 4,
  parameter int MODE_W   = 2,
  parameter int BYTE_OFS = 1,
  parameter int MIN_ADDR = 'h100,
  parameter logic [ADDR_W-BLK_W+MODE_W-1:0] RST_VAL = 8'h80
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  cfgStrobe_t                          strobe,
  input  logic [ADDR_W-BLK_W+MODE_W-1:0]      wrData,
  output logic [ADDR_W-BLK_W+MODE_W-1:0]      rdData,
  input  logic [ADDR_W-1:0]                   ioAddr,
  input  logic                                csInN,
  input  logic                                addr10,
  input  logic                                gameOff,
  output logic                                gameCsN
);

  localparam int BASE_W = ADDR_W - BLK_W;
  localparam int DATA_W = BASE_W + MODE_W;
  localparam logic [BASE_W-1:0] MIN_BASE = BASE_W'(MIN_ADDR >> BLK_W);
  localparam logic [BLK_W-1:0]  OFS_VAL  = BLK_W'(BYTE_OFS);

  logic [DATA_W-1:0] regQ;
  logic [BASE_W-1:0] regBase;
  decMode_t          regMode;
  logic              baseOk;
  logic              highHit;
  logic              lowHit;
  logic              qualOk;
  logic              match;

  // Configuration register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            regQ <= RST_VAL;
    else if (strobe.wrEn) regQ <= wrData;
  end

  assign rdData  = strobe.rdEn ? regQ : '0;
  assign regBase = regQ[DATA_W-1:MODE_W];
  assign regMode = decMode_t'(regQ[MODE_W-1:0]);

  // The lower cutoff on the base only exists when the minimum is nonzero.
  generate
    if (MIN_ADDR > 0) begin : g_minBase
      assign baseOk = (regBase >= MIN_BASE);
    end else begin : g_noMinBase
      assign baseOk = 1'b1;
    end
  endgenerate

  assign highHit = (ioAddr[ADDR_W-1:BLK_W] == regBase);

  always_comb begin
    unique case (regMode)
      DEC_OFF:  lowHit = 1'b0;
      DEC_BYTE: lowHit = (ioAddr[BLK_W-1:0] == OFS_VAL);
      DEC_HALF: lowHit = ~ioAddr[BLK_W-1];
      DEC_FULL: lowHit = 1'b1;
      default:  lowHit = 1'b0;
    endcase
  end

  assign qualOk  = ~csInN && ~addr10 && ~gameOff;
  assign match   = qualOk && baseOk && highHit && lowHit;
  assign gameCsN = ~match;

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> (regQ == $past(wrData)));                         // R2
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(regQ));                                  // R3
  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (regQ[MODE_W-1:0] == 2'b00) |-> gameCsN);                         // R5
  AST_QUALIFY_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (csInN || addr10) |-> gameCsN);                                   // R9
  AST_OFF_OVERRIDE: assert property (@(posedge clk) disable iff (!rstN)
    gameOff |-> gameCsN);                                             // R10
  AST_LOW_BASE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (regQ[DATA_W-1:MODE_W] < MIN_BASE) |-> gameCsN);                  // R11
  AST_SELECT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    !gameCsN |-> (ioAddr[ADDR_W-1:BLK_W] == regQ[DATA_W-1:MODE_W]));  // R8

endmodule

// File: rtl/gamecs_top.sv
`timescale 1ns/1ps
module gamecs_top
  import gamecs_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BLK_W     = 4,
  parameter int IDX_W     = 8,
  parameter logic [IDX_W-1:0] CFG_INDEX = 8'h1E,
  parameter int MIN_ADDR  = 'h100,
  parameter logic [7:0] RST_VAL = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgActive,
  input  logic [IDX_W-1:0]  cfgIndex,
  input  logic              cfgWrite,
  input  logic              cfgRead,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              csInN,
  input  logic              addr10,
  input  logic              gameOff,
  output logic              gameCsN
);

  localparam int MODE_W = 2;

  cfgStrobe_t strobe;

  gamecs_ctrl #(
    .IDX_W     (IDX_W),
    .CFG_INDEX (CFG_INDEX)
  ) u_ctrl (
    .cfgActive (cfgActive),
    .cfgIndex  (cfgIndex),
    .cfgWrite  (cfgWrite),
    .cfgRead   (cfgRead),
    .strobe    (strobe)
  );

  gamecs_dp #(
    .ADDR_W   (ADDR_W),
    .BLK_W    (BLK_W),
    .MODE_W   (MODE_W),
    .BYTE_OFS (1),
    .MIN_ADDR (MIN_ADDR),
    .RST_VAL  (RST_VAL)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (cfgWdata),
    .rdData  (cfgRdata),
    .ioAddr  (ioAddr),
    .csInN   (csInN),
    .addr10  (addr10),
    .gameOff (gameOff),
    .gameCsN (gameCsN)
  );

  AST_RD_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgActive || (cfgIndex != CFG_INDEX) || !cfgRead) |-> (cfgRdata == 8'h00)); // R4

endmodule

// File: tb/gamecs_top_tb.sv
`timescale 1ns/1ps
module gamecs_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgActive = 1'b0;
  logic [7:0] cfgIndex = 8'h00;
  logic       cfgWrite = 1'b0;
  logic       cfgRead = 1'b0;
  logic [7:0] cfgWdata = 8'h00;
  logic [7:0] cfgRdata;
  logic [9:0] ioAddr = 10'h000;
  logic       csInN = 1'b1;
  logic       addr10 = 1'b0;
  logic       gameOff = 1'b0;
  logic       gameCsN;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  gamecs_top u_dut (
    .clk (clk), .rstN (rstN), .cfgActive (cfgActive), .cfgIndex (cfgIndex),
    .cfgWrite (cfgWrite), .cfgRead (cfgRead), .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata), .ioAddr (ioAddr), .csInN (csInN), .addr10 (addr10),
    .gameOff (gameOff), .gameCsN (gameCsN)
  );

  // {reg[7:0], addr[9:0], csInN, addr10, gameOff, expected gameCsN, requirement}
  localparam int NV = 24;
  localparam logic [25:0] VEC [NV] = '{
    {8'h80, 10'h200, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5},   // R5 mode off
    {8'h81, 10'h201, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},   // R6 offset 1 hits
    {8'h81, 10'h200, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},   // R6 offset 0 misses
    {8'h81, 10'h202, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},   // R6 offset 2 misses
    {8'h81, 10'h211, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},   // R6 next window
    {8'h82, 10'h200, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},   // R7 offset 0
    {8'h82, 10'h207, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},   // R7 offset 7
    {8'h82, 10'h208, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},   // R7 offset 8
    {8'h82, 10'h1F7, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},   // R7 previous window
    {8'h83, 10'h200, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},   // R8 offset 0
    {8'h83, 10'h20F, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},   // R8 offset F
    {8'h83, 10'h210, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8},   // R8 above
    {8'h83, 10'h1FF, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8},   // R8 below
    {8'hFF, 10'h3F5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},   // R8 top base 3F0h
    {8'h43, 10'h105, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},   // R8 bottom base 100h
    {8'h43, 10'h0F5, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8},   // R8 under bottom base
    {8'h3F, 10'h0F3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd11},  // R11 base 0F0h
    {8'h03, 10'h000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd11},  // R11 base 000h
    {8'h83, 10'h205, 1'b1, 1'b0, 1'b0, 1'b1, 4'd9},   // R9 host cs high
    {8'h83, 10'h205, 1'b0, 1'b1, 1'b0, 1'b1, 4'd9},   // R9 addr10 high
    {8'h83, 10'h205, 1'b0, 1'b0, 1'b1, 1'b1, 4'd10},  // R10 disable high
    {8'h81, 10'h201, 1'b0, 1'b0, 1'b1, 1'b1, 4'd10},  // R10 byte mode disabled
    {8'h83, 10'h205, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},   // R8 fully qualified
    {8'h80, 10'h205, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5}    // R5 back to off
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic act, input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk);
    cfgActive = act; cfgIndex = idx; cfgWdata = val; cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0; cfgActive = 1'b0; cfgIndex = 8'h00;
  endtask

  task automatic readReg(input logic act, input logic [7:0] idx, output logic [7:0] val);
    @(negedge clk);
    cfgActive = act; cfgIndex = idx; cfgRead = 1'b1;
    #1 val = cfgRdata;
    cfgRead = 1'b0; cfgActive = 1'b0; cfgIndex = 8'h00;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state, select inactive during and after reset
    check(1, {7'd0, gameCsN}, 8'h01);
    rstN = 1'b1;
    readReg(1'b1, 8'h1E, rd);
    check(1, rd, 8'h80);

    // R4: reads outside configuration state or at another index return zero
    readReg(1'b0, 8'h1E, rd);
    check(4, rd, 8'h00);
    readReg(1'b1, 8'h1F, rd);
    check(4, rd, 8'h00);

    // R2: qualified write lands
    writeReg(1'b1, 8'h1E, 8'h5A);
    readReg(1'b1, 8'h1E, rd);
    check(2, rd, 8'h5A);

    // R3: unqualified writes ignored, observed by reading back
    writeReg(1'b0, 8'h1E, 8'hC3);
    readReg(1'b1, 8'h1E, rd);
    check(3, rd, 8'h5A);
    writeReg(1'b1, 8'h1D, 8'hC3);
    readReg(1'b1, 8'h1E, rd);
    check(3, rd, 8'h5A);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      writeReg(1'b1, 8'h1E, v[25:18]);
      ioAddr = v[17:8]; csInN = v[7]; addr10 = v[6]; gameOff = v[5];
      #1;
      check(int'(v[3:0]), {7'd0, gameCsN}, {7'd0, v[4]});
    end

    // R12: combinational response, no clock edge between address changes
    writeReg(1'b1, 8'h1E, 8'h81);
    csInN = 1'b0; addr10 = 1'b0; gameOff = 1'b0;
    ioAddr = 10'h201;
    #1 check(12, {7'd0, gameCsN}, 8'h00);
    ioAddr = 10'h202;
    #1 check(12, {7'd0, gameCsN}, 8'h01);
    ioAddr = 10'h201;
    #1 check(12, {7'd0, gameCsN}, 8'h00);

    // R4: qualified read returns the programmed value
    readReg(1'b1, 8'h1E, rd);
    check(4, rd, 8'h81);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule